// File: doc/BRIEF.md
# Indexed CMOS Register File

This block is a byte-wide register file of 256 entries that a host reaches through two byte ports. A strobe on the index port latches the number of the register to use. Strobes on the data port then read or write that register. Each entry carries a valid bit. An entry that has never been written reads back as zero, and the read also raises a one-cycle "unset" flag.

The block continuously presents the two control bytes at entries 0x0A (status A) and 0x0B (status B) to a companion clock block. That clock block may push new values into the time and status bytes at entries 0x00 through 0x0D. Every data-port read of status A inverts bit 7 of that register afterwards, so software polling the update-busy flag sees it alternate.

Top module: `cmos_regfile`

## Requirements
- R1: An index strobe stores only bits 6:0 of `host_wdata`. Bit 7 has no effect, so indices 0x85 and 0x05 select the same entry.
- R2: A data write stores `host_wdata` in the selected entry and marks the entry valid. A later data read returns that byte on `rd_data` in the cycle after the read strobe.
- R3: A data read of an entry whose valid bit is clear returns 0x00 and drives `rd_unset` high for exactly that one result cycle. A read of a valid entry leaves `rd_unset` low.
- R4: A data read of entry 0x0A returns its current value. Bit 7 of entry 0x0A is then inverted, so two back-to-back reads return values that differ only in bit 7.
- R5: After reset the index is 0, and only entries 0x0A..0x0D are valid, holding 0x26, 0x02, 0x00 and 0x80. All other entries read as unset.
- R6: `stat_a` and `stat_b` always show the stored contents of entries 0x0A and 0x0B.
- R7: A clock-side update (`clk_upd` high) writes `clk_data` to `clk_addr` and marks that entry valid, but only when `clk_addr` is 0x0D or below. An update to a higher address changes nothing.
- R8: When a data write and a clock-side update target the same entry in one cycle, the data write's byte is stored. For entry 0x0A, a data write also overrides the read toggle.
- R9: `rd_data` and `rd_unset` change only in the cycle after a read strobe. Without a read, `rd_data` holds its value and `rd_unset` is low.
- R10: A read and a write of the same entry in one cycle return the old contents, and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Index port write strobe |
| dat_wr | input | 1 | Data port write strobe |
| dat_rd | input | 1 | Data port read strobe |
| host_wdata | input | 8 | Byte written through the index or data port |
| rd_data | output | 8 | Registered read result |
| rd_unset | output | 1 | Pulses with a read result from a never-written entry |
| clk_upd | input | 1 | Clock-side update strobe |
| clk_addr | input | 8 | Entry targeted by the clock-side update |
| clk_data | input | 8 | Byte written by the clock-side update |
| stat_a | output | 8 | Live contents of status A (entry 0x0A) |
| stat_b | output | 8 | Live contents of status B (entry 0x0B) |

## Verification
The index path is driven with bytes that have bit 7 both set and clear. Aliased reads therefore expose any leak of that bit into the stored index. Data reads cover written entries, never-written entries and the reset-default status bytes, which separates true storage from the zero fill for invalid entries. Repeated reads of status A show whether the toggle fires once per read and after the value is captured. Same-cycle collisions (write with clock update, write with read) and clock updates above the allowed range separate the priority order from plain last-write behaviour.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ENTRY_CNT  = 256;
  localparam int unsigned ADDR_W     = $clog2(ENTRY_CNT);
  localparam int unsigned INDEX_W    = 7;

  localparam logic [ADDR_W-1:0] ADR_CTL_A = 8'h0A;
  localparam logic [ADDR_W-1:0] ADR_CTL_B = 8'h0B;
  localparam logic [ADDR_W-1:0] ADR_CTL_C = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_CTL_D = 8'h0D;
  localparam logic [ADDR_W-1:0] ADR_CLK_TOP = 8'h0D;

  localparam int unsigned BUSY_BIT = 7;

  function automatic logic [BYTE_W-1:0] init_byte(input int unsigned e);
    case (e)
      32'h0A:  init_byte = 8'h26;
      32'h0B:  init_byte = 8'h02;
      32'h0C:  init_byte = 8'h00;
      32'h0D:  init_byte = 8'h80;
      default: init_byte = 8'h00;
    endcase
  endfunction

  function automatic logic init_valid(input int unsigned e);
    init_valid = (e >= 32'h0A) && (e <= 32'h0D);
  endfunction
endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] index
);
  logic [IW-1:0] idx_d, idx_q;

  always_comb begin
    idx_d = idx_q;
    if (wr_en) idx_d = wdata[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (wr_en) idx_q <= idx_d;
  end

  assign index = idx_q;

  // R1: only the low index bits are retained
  p_index_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> index == $past(wdata[IW-1:0]));
endmodule

// File: rtl/cmos_valid_map.sv
module cmos_valid_map
  import cmos_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_a,
  input  logic [AW-1:0]    addr_a,
  input  logic             set_b,
  input  logic [AW-1:0]    addr_b,
  output logic [DEPTH-1:0] valid
);
  localparam int unsigned ROW_W = 8;
  localparam int unsigned ROWS  = DEPTH / ROW_W;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_W-1:0] row_d, row_q;
    logic             row_en;

    always_comb begin
      row_d = row_q;
      for (int b = 0; b < ROW_W; b++) begin
        if ((set_a && addr_a == AW'(r*ROW_W+b)) ||
            (set_b && addr_b == AW'(r*ROW_W+b)))
          row_d[b] = 1'b1;
      end
      row_en = (row_d != row_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int b = 0; b < ROW_W; b++) row_q[b] <= init_valid(r*ROW_W+b);
      end else if (row_en) begin
        row_q <= row_d;
      end
    end

    assign valid[r*ROW_W +: ROW_W] = row_q;
  end

  // R2: a write marks its entry valid for good
  p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_a |=> valid[$past(addr_a)]);
  // R7: clock-side update also marks the entry valid
  p_valid_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_b |=> valid[$past(addr_b)]);
endmodule

// File: rtl/cmos_store.sv
module cmos_store
  import cmos_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_data,
  input  logic                      upd_we,
  input  logic [AW-1:0]             upd_addr,
  input  logic [DW-1:0]             upd_data,
  input  logic                      tog_busy,
  output logic [DEPTH-1:0][DW-1:0]  mem
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DW-1:0] ent_d, ent_q;
    logic          ent_en;
    logic          hit_bus, hit_upd, hit_tog;

    assign hit_bus = bus_we && (bus_addr == AW'(e));
    assign hit_upd = upd_we && (upd_addr == AW'(e));
    assign hit_tog = tog_busy && (AW'(e) == ADR_CTL_A);

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (hit_bus) begin
        ent_d  = bus_data;
        ent_en = 1'b1;
      end else if (hit_upd) begin
        ent_d  = upd_data;
        ent_en = 1'b1;
      end else if (hit_tog) begin
        ent_d  = ent_q ^ (DW'(1) << BUSY_BIT);
        ent_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= init_byte(e);
      else if (ent_en) ent_q <= ent_d;
    end

    assign mem[e] = ent_q;
  end

  // R8: bus write beats a clock update to the same entry
  p_bus_over_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && upd_we && bus_addr == upd_addr) |=> mem[$past(bus_addr)] == $past(bus_data));
  // R2: bus write content lands in the entry
  p_bus_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> mem[$past(bus_addr)] == $past(bus_data));
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_pkg::*;
#(
  parameter int unsigned DEPTH = ENTRY_CNT,
  parameter int unsigned DW    = BYTE_W,
  parameter int unsigned IW    = INDEX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_unset,
  input  logic          clk_upd,
  input  logic [7:0]    clk_addr,
  input  logic [DW-1:0] clk_data,
  output logic [DW-1:0] stat_a,
  output logic [DW-1:0] stat_b
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [IW-1:0]            index;
  logic [AW-1:0]            sel_addr;
  logic [AW-1:0]            upd_addr;
  logic                     upd_ok;
  logic                     tog_busy;
  logic [DEPTH-1:0]         valid;
  logic [DEPTH-1:0][DW-1:0] mem;
  logic [DW-1:0]            rd_d, rd_q;
  logic                     uns_d, uns_q;

  cmos_index_reg #(.DW(DW), .IW(IW)) u_index (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (idx_wr),
    .wdata (host_wdata),
    .index (index)
  );

  assign sel_addr = AW'(index);
  assign upd_addr = AW'(clk_addr);
  assign upd_ok   = clk_upd && (clk_addr <= 8'(ADR_CLK_TOP));
  assign tog_busy = dat_rd && (sel_addr == ADR_CTL_A);

  cmos_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (dat_wr),
    .bus_addr (sel_addr),
    .bus_data (host_wdata),
    .upd_we   (upd_ok),
    .upd_addr (upd_addr),
    .upd_data (clk_data),
    .tog_busy (tog_busy),
    .mem      (mem)
  );

  cmos_valid_map #(.DEPTH(DEPTH), .AW(AW)) u_valid (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_a  (dat_wr),
    .addr_a (sel_addr),
    .set_b  (upd_ok),
    .addr_b (upd_addr),
    .valid  (valid)
  );

  always_comb begin
    rd_d  = rd_q;
    uns_d = 1'b0;
    if (dat_rd) begin
      rd_d  = valid[sel_addr] ? mem[sel_addr] : '0;
      uns_d = !valid[sel_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (dat_rd) rd_q <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uns_q <= 1'b0;
    else        uns_q <= uns_d;
  end

  assign rd_data  = rd_q;
  assign rd_unset = uns_q;
  assign stat_a   = mem[ADR_CTL_A];
  assign stat_b   = mem[ADR_CTL_B];

  // R3: an unset result always carries zero data
  p_unset_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unset |-> rd_data == '0);
  // R9: result holds without a read, flag stays low
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_rd |=> ($stable(rd_data) && !rd_unset));
  // R4: a plain read of status A flips its busy bit
  p_busy_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_busy && !dat_wr && !(upd_ok && upd_addr == ADR_CTL_A))
      |=> stat_a[BUSY_BIT] != $past(stat_a[BUSY_BIT]));
  // R7: out-of-range clock updates leave status bytes untouched
  p_upd_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_upd && clk_addr > 8'(ADR_CLK_TOP) && !dat_wr && !dat_rd) |=> $stable(stat_b));
endmodule

// File: tb/cmos_regfile_tb.sv
module cmos_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       idx_wr, dat_wr, dat_rd, clk_upd;
  logic [7:0] host_wdata, clk_addr, clk_data;
  logic [7:0] rd_data, stat_a, stat_b;
  logic       rd_unset;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  cmos_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .host_wdata(host_wdata), .rd_data(rd_data), .rd_unset(rd_unset),
    .clk_upd(clk_upd), .clk_addr(clk_addr), .clk_data(clk_data),
    .stat_a(stat_a), .stat_b(stat_b)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    idx_wr = 0; dat_wr = 0; dat_rd = 0; clk_upd = 0;
  endtask

  task automatic set_index(input logic [7:0] v);
    @(negedge clk); idle(); idx_wr = 1; host_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); idle(); dat_wr = 1; host_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic rd(output logic [7:0] d, output logic u);
    @(negedge clk); idle(); dat_rd = 1;
    @(negedge clk); idle(); d = rd_data; u = rd_unset;
  endtask

  task automatic upd(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); idle(); clk_upd = 1; clk_addr = a; clk_data = v;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [7:0] d; logic u;
    check("R5 stat_a", stat_a, 8'h26);
    check("R5 stat_b", stat_b, 8'h02);
    rd(d, u);
    check("R5 idx0 data", d, 8'h00);
    check("R5 idx0 unset", {7'b0, u}, 8'h01);
    set_index(8'h0C); rd(d, u);
    check("R5 ctlC", d, 8'h00);
    check("R3 ctlC not unset", {7'b0, u}, 8'h00);
    set_index(8'h0D); rd(d, u);
    check("R5 ctlD", d, 8'h80);
  endtask

  task automatic t_busy_toggle();
    logic [7:0] d; logic u;
    set_index(8'h0A);
    rd(d, u);
    check("R4 first read", d, 8'h26);
    check("R4 stat_a after", stat_a, 8'hA6);
    rd(d, u);
    check("R4 second read", d, 8'hA6);
    check("R6 stat_a back", stat_a, 8'h26);
  endtask

  task automatic t_index_alias();
    logic [7:0] d; logic u;
    set_index(8'h85); wr_data(8'h5A);
    set_index(8'h05); rd(d, u);
    check("R1 alias 0x85->0x05", d, 8'h5A);
    set_index(8'h85); rd(d, u);
    check("R1 bit7 ignored read", d, 8'h5A);
  endtask

  task automatic t_write_read();
    logic [7:0] d; logic u;
    set_index(8'h40); wr_data(8'hC3); rd(d, u);
    check("R2 readback", d, 8'hC3);
    check("R2 valid flag", {7'b0, u}, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 data holds", rd_data, 8'hC3);
    check("R9 unset low", {7'b0, rd_unset}, 8'h00);
  endtask

  task automatic t_unset();
    logic [7:0] d; logic u;
    set_index(8'h41); rd(d, u);
    check("R3 zero", d, 8'h00);
    check("R3 flag", {7'b0, u}, 8'h01);
    @(negedge clk);
    check("R3 one cycle", {7'b0, rd_unset}, 8'h00);
  endtask

  task automatic t_clock_side();
    logic [7:0] d; logic u;
    upd(8'h03, 8'h17);
    set_index(8'h03); rd(d, u);
    check("R7 in range", d, 8'h17);
    check("R7 valid", {7'b0, u}, 8'h00);
    upd(8'h20, 8'h99);
    set_index(8'h20); rd(d, u);
    check("R7 out of range", d, 8'h00);
    check("R7 out of range unset", {7'b0, u}, 8'h01);
    upd(8'h0B, 8'h06);
    check("R6 stat_b update", stat_b, 8'h06);
  endtask

  task automatic t_collide();
    logic [7:0] d; logic u;
    set_index(8'h02);
    @(negedge clk); idle();
    dat_wr = 1; host_wdata = 8'h11; clk_upd = 1; clk_addr = 8'h02; clk_data = 8'h22;
    @(negedge clk); idle();
    rd(d, u);
    check("R8 bus wins", d, 8'h11);
    set_index(8'h40);
    @(negedge clk); idle(); dat_rd = 1; dat_wr = 1; host_wdata = 8'h77;
    @(negedge clk); idle();
    check("R10 old value", rd_data, 8'hC3);
    rd(d, u);
    check("R10 new stored", d, 8'h77);
  endtask

  initial begin
    idle(); host_wdata = 0; clk_addr = 0; clk_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_busy_toggle();
    t_index_alias();
    t_write_read();
    t_unset();
    t_clock_side();
    t_collide();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule